// File: doc/BRIEF.md
# Serial Transmitter with Exact Break and Idle Frames

This block serialises words onto a single output line, one bit per pulse of an externally supplied bit-rate tick. Besides ordinary data frames it can send two special frames, each as long as a data frame: a break frame drives the line low for the whole frame, and an idle frame keeps it high for the whole frame. Every frame starts on a tick and begins straight after the previous one ends, so the length of a break is set only by the word length and never by when the request arrived.

A word is handed over through a one-entry holding register with a valid/ready handshake. A break is requested through a level input. A short pulse is remembered and sent as exactly one break. Holding the level high keeps breaks coming back to back, and each frame boundary where the level is still high adds exactly one more break. An idle frame is queued each time the transmit enable goes from low to high. When several requests wait at a frame boundary, the idle frame goes first, then the break, then the data word.

The controller has three states. `ST_OFF` means transmission is disabled. `ST_WAIT` means it is enabled and waiting for work. `ST_SEND` means a frame is on the line. The transitions are:
- `ST_OFF` goes to `ST_WAIT` when enable is 1.
- `ST_WAIT` goes to `ST_OFF` when enable is 0.
- `ST_WAIT` goes to `ST_SEND` on a tick with any request pending.
- `ST_SEND` stays in `ST_SEND` on the tick that ends a frame, when enable is 1 and another request is pending (back to back).
- `ST_SEND` goes to `ST_WAIT` on the tick that ends a frame with nothing pending, or to `ST_OFF` on that tick if enable is 0.

Top module: `uart_brk_tx`

## Requirements
- R1: During and right after reset, `txd` is 1, `busy` is 0 and `load_ready` is 1.
- R2: A data frame is one low start bit, then the data bits least significant first (8 bits when `long_word`=0, 9 bits when `long_word`=1), then one high stop bit. Each bit lasts one tick period.
- R3: A `send_brk` pulse that falls before the next frame boundary gives exactly one break: N consecutive low bit periods, where N is 10 for `long_word`=0 and 11 for `long_word`=1. The break is never 2N.
- R4: While `send_brk` stays 1, break frames follow each other back to back. Every frame boundary reached with the level high adds one break. Releasing the level in the middle of a break adds none.
- R5: A 0-to-1 change of `tx_enable` queues one idle frame: N bit periods with `busy`=1 and `txd`=1.
- R6: A break requested right after an idle request gives the idle frame followed by a break of exactly N low bit periods, never 2N.
- R7: A `send_brk` pulse that arrives during a frame is remembered. It is sent as one break straight after that frame.
- R8: At a frame boundary the pending requests are served in this order: idle first, then break, then the held data word.
- R9: `busy` rises on the tick that starts a frame and falls on the tick that ends the last frame. A lone frame keeps `busy` high for exactly N tick periods.
- R10: The word length is captured when a frame starts. Changing `long_word` during a frame has no effect on that frame.
- R11: A word is taken when `load_valid` and `load_ready` are both 1. `load_ready` stays 0 until that word's frame starts. A load offered while `load_ready` is 0 is ignored.
- R12: While `tx_enable` is 0 no frame starts and the line stays high. Whenever `busy` is 0, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_enable | input | 1 | Transmit enable; a rising edge queues an idle frame |
| send_brk | input | 1 | Break request, level sensitive |
| long_word | input | 1 | 0: 8 data bits, 1: 9 data bits |
| load_valid | input | 1 | Offer a word to send |
| load_data | input | DATA_W | Word to send, bit 0 goes first |
| load_ready | output | 1 | Holding register is empty |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is on the line |

## Verification
The line and `busy` change only on a clock edge where `bit_tick` is 1. A frame starts one clock after the tick on which it is chosen, and each later bit appears one tick period after the one before it. The bench therefore records `txd` and `busy` at the falling clock edge that follows every tick, which yields one sample per bit period. It then checks frame lengths, bit values and counts of low periods from that record, counted from the first sample where `busy` is high. `load_ready` changes one clock after the accepting edge and is sampled at the next falling edge.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        FK_DATA  = 2'd0,
        FK_BREAK = 2'd1,
        FK_IDLE  = 2'd2
    } frame_kind_e;

endpackage

// File: rtl/uart_brk_req.sv
module uart_brk_req (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en_i,
    input  logic brk_i,
    input  logic take_idle_i,
    input  logic take_brk_i,
    output logic idle_act_o,
    output logic brk_act_o
);

    logic en_prev;
    logic brk_prev;
    logic idle_pend;
    logic brk_pend;
    logic en_rise;
    logic brk_rise;

    assign en_rise    = tx_en_i & ~en_prev;
    assign brk_rise   = brk_i & ~brk_prev;
    assign idle_act_o = idle_pend | en_rise;
    assign brk_act_o  = brk_pend | brk_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_prev   <= 1'b0;
            brk_prev  <= 1'b0;
            idle_pend <= 1'b0;
            brk_pend  <= 1'b0;
        end else begin
            en_prev   <= tx_en_i;
            brk_prev  <= brk_i;
            idle_pend <= ~take_idle_i & (idle_pend | en_rise);
            brk_pend  <= ~take_brk_i & (brk_pend | brk_rise);
        end
    end

    // R5: an unserved idle request survives to the next cycle
    a_r5_idle_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_act_o && !take_idle_i) |=> idle_act_o);

    // R7: a break edge that is not served at once is remembered
    a_r7_brk_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_i && !brk_prev && !take_brk_i) |=> brk_act_o);

endmodule

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              take_i,
    output logic              ready_o,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    assign ready_o = ~full_q;
    assign full_o  = full_q;
    assign data_o  = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take_i) begin
            full_q <= 1'b0;
        end else if (load_valid_i && !full_q) begin
            full_q <= 1'b1;
            data_q <= load_data_i;
        end
    end

    // R11: the held word remains until its frame starts
    a_r11_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !take_i) |=> full_q);

    // R11: an offer while full leaves the held word untouched
    a_r11_offer_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && load_valid_i) |=> $stable(data_q));

endmodule

// File: rtl/uart_brk_shift.sv
module uart_brk_shift #(
    parameter int unsigned FRAME_W = 11,
    parameter int unsigned CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] load_bits_i,
    input  logic [CNT_W-1:0]   load_len_i,
    input  logic               step_i,
    input  logic               idle_i,
    output logic               txd_o,
    output logic               last_o
);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;

    assign txd_o  = shreg[0];
    assign last_o = (left == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
        end else if (load_i) begin
            shreg <= load_bits_i;
            left  <= load_len_i - CNT_W'(1);
        end else if (idle_i) begin
            shreg <= '1;
            left  <= '0;
        end else if (step_i && (left != '0)) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - CNT_W'(1);
        end
    end

    // R2: a bit stays on the line between ticks
    a_r2_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i && !idle_i) |=> $stable(txd_o));

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_enable,
    input  logic              send_brk,
    input  logic              long_word,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              load_ready,
    output logic              txd,
    output logic              busy
);

    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);

    tx_state_e   state_q, state_d;
    frame_kind_e kind;

    logic              idle_act, brk_act;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              last;
    logic              at_edge, start, frame_end, step;
    logic              take_idle, take_brk, take_data;
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   len;

    uart_brk_req u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en_i    (tx_enable),
        .brk_i      (send_brk),
        .take_idle_i(take_idle),
        .take_brk_i (take_brk),
        .idle_act_o (idle_act),
        .brk_act_o  (brk_act)
    );

    uart_brk_hold #(.DATA_W(DATA_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_valid_i(load_valid),
        .load_data_i (load_data),
        .take_i      (take_data),
        .ready_o     (load_ready),
        .full_o      (hold_full),
        .data_o      (hold_data)
    );

    uart_brk_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .load_bits_i(bits),
        .load_len_i (len),
        .step_i     (step),
        .idle_i     (frame_end),
        .txd_o      (txd),
        .last_o     (last)
    );

    // Frame boundary decision and request priority
    always_comb begin
        at_edge = bit_tick && tx_enable &&
                  ((state_q == ST_WAIT) || ((state_q == ST_SEND) && last));
        if (idle_act) begin
            kind = FK_IDLE;
        end else if (brk_act) begin
            kind = FK_BREAK;
        end else begin
            kind = FK_DATA;
        end
        take_idle = at_edge && (kind == FK_IDLE);
        take_brk  = at_edge && (kind == FK_BREAK);
        take_data = at_edge && (kind == FK_DATA) && hold_full;
        start     = take_idle || take_brk || take_data;
        frame_end = bit_tick && (state_q == ST_SEND) && last && !start;
        step      = bit_tick && (state_q == ST_SEND) && !last;
        len       = long_word ? LEN_LONG : LEN_SHORT;
    end

    // Frame image, bit 0 goes on the line first
    always_comb begin
        bits = '1;
        unique case (kind)
            FK_IDLE:  bits = '1;
            FK_BREAK: bits = '0;
            FK_DATA: begin
                bits[0] = 1'b0;
                for (int i = 0; i < DATA_W; i++) begin
                    if (long_word || (i < DATA_W - 1)) begin
                        bits[i+1] = hold_data[i];
                    end
                end
            end
            default:  bits = '1;
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (tx_enable) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!tx_enable)  state_d = ST_OFF;
                else if (start)  state_d = ST_SEND;
            end
            ST_SEND: begin
                if (frame_end) state_d = tx_enable ? ST_WAIT : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy = (state_q == ST_SEND);
    end

    // R12: the line is high whenever no frame is on it
    a_r12_high_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R9: busy moves only on a tick
    a_r9_busy_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> (busy == $past(busy)));

    // R3: a chosen break puts the line low at once
    a_r3_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        take_brk |=> (!txd && busy));

    // R5: a chosen idle frame keeps the line high while busy
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        take_idle |=> (txd && busy));

    // R2: a data frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        take_data |=> (!txd && busy));

endmodule

// File: tb/uart_brk_tx_bench.sv
module uart_brk_tx_bench;

    typedef struct packed {
        logic       lw;
        logic [8:0] d;
        logic [3:0] len;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 9'h0A5, 4'd10},
        '{1'b0, 9'h000, 4'd10},
        '{1'b1, 9'h1A5, 4'd11},
        '{1'b1, 9'h100, 4'd11},
        '{1'b0, 9'h001, 4'd10},
        '{1'b1, 9'h0FE, 4'd11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_enable = 1'b0;
    logic       send_brk = 1'b0;
    logic       long_word = 1'b0;
    logic       load_valid = 1'b0;
    logic [8:0] load_data = '0;
    logic       load_ready;
    logic       txd;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;

    logic rec_t [0:1023];
    logic rec_b [0:1023];
    int   rec_n = 0;
    logic tick_d = 1'b0;

    uart_brk_tx u_uart_brk_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_enable (tx_enable),
        .send_brk  (send_brk),
        .long_word (long_word),
        .load_valid(load_valid),
        .load_data (load_data),
        .load_ready(load_ready),
        .txd       (txd),
        .busy      (busy)
    );

    // 250 MHz: 4 time units per period
    always #2 clk = ~clk;

    // Tick generator: one pulse every four clocks
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            bit_tick <= (cnt == 3);
            cnt = (cnt + 1) % 4;
        end
    end

    // Record one sample per bit period, after the tick edge
    always @(posedge clk) tick_d <= bit_tick;
    always @(negedge clk) begin
        if (tick_d && rec_n < 1024) begin
            rec_t[rec_n] = txd;
            rec_b[rec_n] = busy;
            rec_n = rec_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic send_word(input logic [8:0] d);
        @(negedge clk);
        while (!load_ready) @(negedge clk);
        load_valid = 1'b1;
        load_data  = d;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic pulse_brk();
        @(negedge clk);
        send_brk = 1'b1;
        @(negedge clk);
        send_brk = 1'b0;
    endtask

    function automatic int find_busy(input int from);
        for (int i = from; i < rec_n; i++) if (rec_b[i]) return i;
        return -1;
    endfunction

    function automatic int busy_run(input int s);
        int n = 0;
        if (s < 0) return 0;
        for (int i = s; i < rec_n; i++) begin
            if (!rec_b[i]) break;
            n++;
        end
        return n;
    endfunction

    function automatic int lows(input int s, input int e);
        int n = 0;
        if (s < 0) return 0;
        for (int i = s; i < e && i < rec_n; i++) if (!rec_t[i]) n++;
        return n;
    endfunction

    function automatic logic exp_bit(input logic lw, input logic [8:0] d, input int i);
        int nd = lw ? 9 : 8;
        if (i == 0) return 1'b0;
        if (i <= nd) return d[i-1];
        return 1'b1;
    endfunction

    function automatic int frame_mism(input int s, input logic lw, input logic [8:0] d);
        int n = 0;
        int len = lw ? 11 : 10;
        if (s < 0) return len;
        for (int i = 0; i < len; i++) begin
            if ((s + i >= rec_n) || (rec_t[s+i] !== exp_bit(lw, d, i))) n++;
        end
        return n;
    endfunction

    // Watchdog
    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int m, s, nn;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && busy === 1'b0 && load_ready === 1'b1, "R1 in reset", {txd, busy, load_ready}, 3'b101);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1 && busy === 1'b0 && load_ready === 1'b1, "R1 after reset", {txd, busy, load_ready}, 3'b101);

        // R12: disabled, a word waiting, nothing starts
        m = rec_n;
        send_word(9'h055);
        wait_ticks(15);
        chk(find_busy(m) < 0, "R12 no frame while disabled", find_busy(m), -1);
        chk(lows(m, rec_n) == 0, "R12 line high while disabled", lows(m, rec_n), 0);

        // R5 and R8: enabling sends idle first, then the waiting word
        m = rec_n;
        tx_enable = 1'b1;
        wait_ticks(26);
        s = find_busy(m);
        chk(busy_run(s) == 20, "R5 idle then data busy run", busy_run(s), 20);
        chk(lows(s, s + 10) == 0, "R5 idle frame high", lows(s, s + 10), 0);
        chk(frame_mism(s + 10, 1'b0, 9'h055) == 0, "R8 data after idle", frame_mism(s + 10, 1'b0, 9'h055), 0);

        // R2 and R9: table of data frames
        foreach (VECS[k]) begin
            long_word = VECS[k].lw;
            m = rec_n;
            send_word(VECS[k].d);
            wait_ticks(15);
            s = find_busy(m);
            chk(busy_run(s) == int'(VECS[k].len), "R9 frame length", busy_run(s), int'(VECS[k].len));
            chk(frame_mism(s, VECS[k].lw, VECS[k].d) == 0, "R2 frame bits", frame_mism(s, VECS[k].lw, VECS[k].d), 0);
        end

        // R3: single break pulse at both word lengths
        for (int w = 0; w < 2; w++) begin
            nn = w ? 11 : 10;
            long_word = w[0];
            m = rec_n;
            pulse_brk();
            wait_ticks(2 * nn + 4);
            s = find_busy(m);
            chk(busy_run(s) == nn, "R3 break busy length", busy_run(s), nn);
            chk(lows(m, rec_n) == nn, "R3 break low count", lows(m, rec_n), nn);
        end

        // R4: held break, released inside the second break
        for (int w = 0; w < 2; w++) begin
            nn = w ? 11 : 10;
            long_word = w[0];
            m = rec_n;
            @(negedge clk);
            send_brk = 1'b1;
            wait_ticks(15);
            send_brk = 1'b0;
            wait_ticks(3 * nn);
            s = find_busy(m);
            chk(lows(m, rec_n) == 2 * nn, "R4 held break low count", lows(m, rec_n), 2 * nn);
            chk(busy_run(s) == 2 * nn, "R4 held break busy run", busy_run(s), 2 * nn);
        end

        // R6: idle request then break request at once
        for (int w = 0; w < 2; w++) begin
            nn = w ? 11 : 10;
            long_word = w[0];
            @(negedge clk);
            tx_enable = 1'b0;
            wait_ticks(2);
            m = rec_n;
            tx_enable = 1'b1;
            pulse_brk();
            wait_ticks(3 * nn + 4);
            s = find_busy(m);
            chk(busy_run(s) == 2 * nn, "R6 idle+break busy run", busy_run(s), 2 * nn);
            chk(lows(s, s + nn) == 0, "R6 idle part high", lows(s, s + nn), 0);
            chk(lows(s + nn, s + 2 * nn) == nn, "R6 break part low", lows(s + nn, s + 2 * nn), nn);
            chk(lows(m, rec_n) == nn, "R6 break never doubled", lows(m, rec_n), nn);
        end

        // R7: pulse in the middle of a data frame
        long_word = 1'b0;
        m = rec_n;
        send_word(9'h03C);
        wait_ticks(4);
        pulse_brk();
        wait_ticks(26);
        s = find_busy(m);
        chk(busy_run(s) == 20, "R7 data then break run", busy_run(s), 20);
        chk(frame_mism(s, 1'b0, 9'h03C) == 0, "R7 data frame intact", frame_mism(s, 1'b0, 9'h03C), 0);
        chk(lows(s + 10, s + 20) == 10, "R7 one break after frame", lows(s + 10, s + 20), 10);

        // R8: break and data both pending while disabled
        @(negedge clk);
        tx_enable = 1'b0;
        wait_ticks(2);
        send_word(9'h0C3);
        pulse_brk();
        m = rec_n;
        wait_ticks(3);
        chk(find_busy(m) < 0 && txd === 1'b1, "R12 pending work held off", find_busy(m), -1);
        m = rec_n;
        tx_enable = 1'b1;
        wait_ticks(36);
        s = find_busy(m);
        chk(busy_run(s) == 30, "R8 three frames", busy_run(s), 30);
        chk(lows(s, s + 10) == 0, "R8 idle first", lows(s, s + 10), 0);
        chk(lows(s + 10, s + 20) == 10, "R8 break second", lows(s + 10, s + 20), 10);
        chk(frame_mism(s + 20, 1'b0, 9'h0C3) == 0, "R8 data last", frame_mism(s + 20, 1'b0, 9'h0C3), 0);

        // R10: word length changed mid-frame
        long_word = 1'b1;
        m = rec_n;
        send_word(9'h1F0);
        wait_ticks(3);
        long_word = 1'b0;
        wait_ticks(14);
        s = find_busy(m);
        chk(busy_run(s) == 11, "R10 length kept", busy_run(s), 11);
        chk(frame_mism(s, 1'b1, 9'h1F0) == 0, "R10 ninth bit sent", frame_mism(s, 1'b1, 9'h1F0), 0);

        // R11: handshake, offer while full is dropped
        long_word = 1'b0;
        m = rec_n;
        send_word(9'h011);
        wait_ticks(2);
        send_word(9'h022);
        chk(load_ready === 1'b0, "R11 ready low while held", load_ready, 0);
        load_valid = 1'b1;
        load_data  = 9'h033;
        @(negedge clk);
        load_valid = 1'b0;
        wait_ticks(30);
        s = find_busy(m);
        chk(busy_run(s) == 20, "R11 exactly two frames", busy_run(s), 20);
        chk(frame_mism(s, 1'b0, 9'h011) == 0, "R11 first word", frame_mism(s, 1'b0, 9'h011), 0);
        chk(frame_mism(s + 10, 1'b0, 9'h022) == 0, "R11 second word", frame_mism(s + 10, 1'b0, 9'h022), 0);
        chk(load_ready === 1'b1, "R11 ready again", load_ready, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule